// File: doc/BRIEF.md
# Framed Byte Stream Encoder

This block sits between a source of response packets and a serial slave transmitter. Packets arrive one byte at a time with start and end flags on a valid/ready handshake. Each time the transmitter asks for its next byte, the block hands over exactly one byte of an encoded stream. That stream carries packet framing, a channel field fixed at zero, escaping of reserved byte values, and idle fill.

A packet opens with a start code, a channel code and the channel number. The end code is placed just before the final data byte, not after it. Reserved values are escaped with one of two escape codes. Which code is used depends on whether the byte collides with a framing code or with a line-level code (idle or line escape). Whenever no packet byte is ready, the idle code goes out, so the transmitter always has something to shift.

Top module: `sfe_stream_encoder`

## Requirements
- R1: Each packet starts on the output with 0x7A, then 0x7C, then the channel number 0x00, and only after these does the first data byte (or its escape pair) appear.
- R2: The end code 0x7B is emitted right before the final data byte of a packet. A packet of one byte is sent as 0x7A 0x7C 0x00 0x7B followed by that byte.
- R3: A data byte of value 0x7A, 0x7B, 0x7C or 0x7D is sent as 0x7D followed by the byte XOR 0x20.
- R4: A data byte of value 0x4A or 0x4D is sent as 0x4D followed by the byte XOR 0x20.
- R5: The final data byte after the end code is escaped by the same rules as R3 and R4 (for example, a final 0x7B is sent as 0x7B 0x7D 0x5B).
- R6: The idle code 0x4A is emitted on a request when no packet byte is pending, both between packets and in gaps inside a packet. After reset `tx_byte` holds 0x4A.
- R7: `in_ready` is high only during a `tx_req` cycle with `in_valid` high in which the input byte is consumed. It stays low while a start, channel, channel-number or end code, or the second byte of an escape pair, is produced.
- R8: Each `tx_req` cycle yields exactly one new output byte, available in `tx_byte` from the following cycle. Without `tx_req`, `tx_byte` and the encoder state do not change.
- R9: A valid byte offered outside a packet without the start flag is consumed and dropped, and the output stays idle. A start flag on a byte inside a packet is treated as ordinary data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Packet byte offered |
| in_ready | output | 1 | Packet byte consumed in this cycle |
| in_first | input | 1 | Offered byte is the first of a packet |
| in_last | input | 1 | Offered byte is the last of a packet |
| in_data | input | 8 | Offered packet byte |
| tx_req | input | 1 | Transmitter asks for the next stream byte |
| tx_byte | output | 8 | Most recently produced stream byte |

## Verification
The hardest case to reach from the ports is the ready signal during a single-byte packet whose byte must itself be escaped. In that case the marker phases and the escape pair follow each other with the same input byte held. To reach it, the bench turns off its automatic request generator and issues requests one at a time, checking `in_ready` and the produced byte after every single request. It then runs the stream through a scoreboard with irregular request spacing and gaps inside packets. This covers escaped bytes in the body and in the final position, and a start flag in mid-packet.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  localparam logic [7:0] SOP_CODE   = 8'h7A;
  localparam logic [7:0] EOP_CODE   = 8'h7B;
  localparam logic [7:0] CHAN_CODE  = 8'h7C;
  localparam logic [7:0] PKT_ESC    = 8'h7D;
  localparam logic [7:0] IDLE_CODE  = 8'h4A;
  localparam logic [7:0] LINE_ESC   = 8'h4D;
  localparam logic [7:0] ESC_FLIP   = 8'h20;
  localparam logic [7:0] CHAN_ID    = 8'h00;

  typedef enum logic [2:0] {
    ST_HUNT  = 3'd0,
    ST_CHAN  = 3'd1,
    ST_CNUM  = 3'd2,
    ST_BODY  = 3'd3,
    ST_FINAL = 3'd4,
    ST_ESC2  = 3'd5
  } seq_st_e;

  typedef struct packed {
    logic       esc;
    logic [7:0] first;
    logic [7:0] second;
  } esc_info_t;

endpackage

// File: rtl/sfe_escape_class.sv
module sfe_escape_class
  import sfe_pkg::*;
(
  input  logic [7:0] raw,
  output esc_info_t  info
);

  logic pkt_hit;
  logic line_hit;

  always_comb begin
    pkt_hit  = (raw == SOP_CODE) || (raw == EOP_CODE) ||
               (raw == CHAN_CODE) || (raw == PKT_ESC);
    line_hit = (raw == IDLE_CODE) || (raw == LINE_ESC);
    info.esc    = pkt_hit || line_hit;
    info.second = raw ^ ESC_FLIP;
    if (pkt_hit) begin
      info.first = PKT_ESC;
    end else if (line_hit) begin
      info.first = LINE_ESC;
    end else begin
      info.first = raw;
    end
  end

endmodule

// File: rtl/sfe_sequencer.sv
module sfe_sequencer
  import sfe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_req,
  input  logic       in_valid,
  input  logic       in_first,
  input  logic       in_last,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic [7:0] nxt_byte
);

  seq_st_e    st_q, st_d;
  logic [7:0] hold_q, hold_d;
  logic       ret_hunt_q, ret_hunt_d;
  logic       take;
  esc_info_t  info;

  sfe_escape_class u_cls (
    .raw  (in_data),
    .info (info)
  );

  // next-state logic
  always_comb begin
    st_d       = st_q;
    hold_d     = hold_q;
    ret_hunt_d = ret_hunt_q;
    nxt_byte   = IDLE_CODE;
    take       = 1'b0;
    case (st_q)
      ST_HUNT: begin
        if (in_valid) begin
          if (in_first) begin
            nxt_byte = SOP_CODE;
            st_d     = ST_CHAN;
          end else begin
            take = 1'b1;
          end
        end
      end
      ST_CHAN: begin
        nxt_byte = CHAN_CODE;
        st_d     = ST_CNUM;
      end
      ST_CNUM: begin
        nxt_byte = CHAN_ID;
        st_d     = ST_BODY;
      end
      ST_BODY: begin
        if (in_valid) begin
          if (in_last) begin
            nxt_byte = EOP_CODE;
            st_d     = ST_FINAL;
          end else begin
            take     = 1'b1;
            nxt_byte = info.first;
            if (info.esc) begin
              hold_d     = info.second;
              ret_hunt_d = 1'b0;
              st_d       = ST_ESC2;
            end
          end
        end
      end
      ST_FINAL: begin
        if (in_valid) begin
          take     = 1'b1;
          nxt_byte = info.first;
          if (info.esc) begin
            hold_d     = info.second;
            ret_hunt_d = 1'b1;
            st_d       = ST_ESC2;
          end else begin
            st_d = ST_HUNT;
          end
        end
      end
      ST_ESC2: begin
        nxt_byte = hold_q;
        st_d     = ret_hunt_q ? ST_HUNT : ST_BODY;
      end
      default: begin
        st_d = ST_HUNT;
      end
    endcase
  end

  assign in_ready = tx_req & take;

  // state registers, advanced only on a transmitter request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_HUNT;
      hold_q     <= '0;
      ret_hunt_q <= 1'b0;
    end else if (tx_req) begin
      st_q       <= st_d;
      hold_q     <= hold_d;
      ret_hunt_q <= ret_hunt_d;
    end
  end

  // R7
  ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (tx_req && in_valid));

  // R8
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req |=> $stable(st_q));

endmodule

// File: rtl/sfe_stream_encoder.sv
module sfe_stream_encoder
  import sfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_first,
  input  logic       in_last,
  input  logic [7:0] in_data,
  input  logic       tx_req,
  output logic [7:0] tx_byte
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_sync_n;
  logic [7:0]             nxt_byte;
  logic [7:0]             tx_byte_q;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[SYNC_STAGES-1];

  sfe_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tx_req   (tx_req),
    .in_valid (in_valid),
    .in_first (in_first),
    .in_last  (in_last),
    .in_data  (in_data),
    .in_ready (in_ready),
    .nxt_byte (nxt_byte)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_byte_q <= IDLE_CODE;
    end else if (tx_req) begin
      tx_byte_q <= nxt_byte;
    end
  end
  assign tx_byte = tx_byte_q;

  // R1
  sop_then_chan_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_req && tx_byte == SOP_CODE) |-> (nxt_byte == CHAN_CODE));

  // R1
  chan_then_num_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_req && tx_byte == CHAN_CODE) |-> (nxt_byte == CHAN_ID));

  // R3
  pkt_esc_pair_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_req && tx_byte == PKT_ESC) |-> (nxt_byte == 8'h5A || nxt_byte == 8'h5B ||
                                        nxt_byte == 8'h5C || nxt_byte == 8'h5D));

  // R4
  line_esc_pair_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_req && tx_byte == LINE_ESC) |-> (nxt_byte == 8'h6A || nxt_byte == 8'h6D));

  // R2
  eop_then_final_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_req && tx_byte == EOP_CODE && in_valid) |-> in_ready);

  // R8
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tx_req |=> $stable(tx_byte));

endmodule

// File: tb/sim_sfe_stream_encoder.sv
module sim_sfe_stream_encoder;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_first, in_last, tx_req;
  logic [7:0] in_data;
  logic       in_ready;
  logic [7:0] tx_byte;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  int         checks = 0;
  int         fails  = 0;
  int         cyc    = 0;
  bit         auto_mode = 1'b0;
  bit         req_prev  = 1'b0;
  bit         done      = 1'b0;

  always #5 clk = ~clk;

  sfe_stream_encoder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_last(in_last), .in_data(in_data),
    .tx_req(tx_req), .tx_byte(tx_byte)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  function automatic void push(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endfunction

  function automatic void enc(input logic [7:0] b, input string plain_tag, input bit fin);
    if (b == 8'h7A || b == 8'h7B || b == 8'h7C || b == 8'h7D) begin
      push(8'h7D, fin ? "R5" : "R3");
      push(b ^ 8'h20, fin ? "R5" : "R3");
    end else if (b == 8'h4A || b == 8'h4D) begin
      push(8'h4D, fin ? "R5" : "R4");
      push(b ^ 8'h20, fin ? "R5" : "R4");
    end else begin
      push(b, plain_tag);
    end
  endfunction

  // scoreboard monitor and automatic request generator
  always @(negedge clk) begin
    cyc++;
    if (auto_mode) begin
      if (req_prev && tx_byte != 8'h4A) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", tx_byte, 8'h4A);
        end else begin
          chk(tx_byte == exp_q[0], tag_q[0], tx_byte, exp_q[0]);
          void'(exp_q.pop_front());
          void'(tag_q.pop_front());
        end
      end
      tx_req   = (cyc % 5) != 3;
      req_prev = tx_req;
    end
  end

  task automatic send_pkt(input logic [7:0] p[], input bit gap, input bit mid_first);
    int n = p.size();
    push(8'h7A, "R1");
    push(8'h7C, "R1");
    push(8'h00, "R1");
    for (int i = 0; i < n - 1; i++) enc(p[i], (mid_first && i == 1) ? "R9" : "R1", 1'b0);
    push(8'h7B, "R2");
    enc(p[n-1], "R2", 1'b1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = p[i];
      in_first = (i == 0) || (mid_first && i == 1);
      in_last  = (i == n - 1);
      forever begin
        @(posedge clk);
        if (in_ready) break;
      end
      if (gap && i == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic mreq(input logic [7:0] exp_b, input bit exp_rdy, input string tag);
    bit took;
    @(negedge clk);
    tx_req = 1'b1;
    #1;
    took = in_ready;
    chk(in_ready == exp_rdy, "R7", {7'd0, in_ready}, {7'd0, exp_rdy});
    @(negedge clk);
    tx_req = 1'b0;
    if (took) in_valid = 1'b0;
    #1;
    chk(tx_byte == exp_b, tag, tx_byte, exp_b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 8'h00, 8'h01);
    finish_run();
  end

  initial begin
    logic [7:0] pk[];
    rst_n = 1'b0; tx_req = 1'b0; in_valid = 1'b0;
    in_first = 1'b0; in_last = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_byte == 8'h4A, "R6", tx_byte, 8'h4A);
    chk(in_ready == 1'b0, "R7", {7'd0, in_ready}, 8'h00);

    // single escaped byte packet, one request at a time
    in_valid = 1'b1; in_data = 8'h4A; in_first = 1'b1; in_last = 1'b1;
    mreq(8'h7A, 1'b0, "R1");
    mreq(8'h7C, 1'b0, "R1");
    mreq(8'h00, 1'b0, "R1");
    mreq(8'h7B, 1'b0, "R2");
    mreq(8'h4D, 1'b1, "R4");
    mreq(8'h6A, 1'b0, "R4");
    repeat (3) @(negedge clk);
    #1 chk(tx_byte == 8'h6A, "R8", tx_byte, 8'h6A);
    mreq(8'h4A, 1'b0, "R6");

    // stray byte without start flag is dropped (R9)
    in_valid = 1'b1; in_data = 8'h11; in_first = 1'b0; in_last = 1'b0;
    mreq(8'h4A, 1'b1, "R9");
    mreq(8'h4A, 1'b0, "R9");

    @(negedge clk);
    req_prev = 1'b0;
    auto_mode = 1'b1;

    pk = '{8'h55};                              send_pkt(pk, 1'b0, 1'b0);
    pk = '{8'h12, 8'h7A, 8'h34, 8'h4A, 8'h99};  send_pkt(pk, 1'b0, 1'b0);
    pk = '{8'h7D, 8'h4D, 8'h00};                send_pkt(pk, 1'b1, 1'b0);
    pk = '{8'h01, 8'h02, 8'h7B};                send_pkt(pk, 1'b0, 1'b0);
    pk = '{8'hA0, 8'hA1, 8'h7C};                send_pkt(pk, 1'b0, 1'b1);
    pk = '{8'h4A};                              send_pkt(pk, 1'b0, 1'b0);
    pk = '{8'h4D, 8'h7A};                       send_pkt(pk, 1'b1, 1'b0);

    for (int w = 0; w < 200 && exp_q.size() != 0; w++) @(negedge clk);
    repeat (10) @(negedge clk);
    auto_mode = 1'b0;
    chk(exp_q.size() == 0, "R8", exp_q.size()[7:0], 8'h00);
    @(negedge clk);
    tx_req = 1'b0;
    finish_run();
  end

endmodule